// File: doc/BRIEF.md
# Double-Buffered VBI Line Buffer

This block sits between a VBI data slicer and a shared output bus. It collects the sliced text bytes of one video line at a time into one of two byte sections. A line becomes available for output only when the slicer marks its end. At that point the section is locked and a transfer request is raised. While that section waits or is being read, the next line fills the other section.

When the bus grants the request, the line leaves as one unbroken burst. The burst opens with a three-byte header carrying an identifier, the line number and the video standard code, and the payload follows it. The qualifier stays high on every byte of the burst. An optional recoding step keeps the two byte values 00H and FFH out of the payload. A line that arrives while both sections are still occupied is thrown away, and a sticky flag records the loss.

Top module: `vbi_line_pingpong`

## Requirements
- R1: After reset, rd_req, rd_valid and drop_flag are all low and no line is buffered.
- R2: rd_req stays low while a line is still being written. It goes high in the cycle after the line_end cycle that completes a line.
- R3: A grant sampled while rd_req is high starts a burst in the next cycle. rd_valid is then high for exactly (stored length + 3) consecutive cycles, and rd_req is low throughout the burst.
- R4: Burst bytes 0 to 2 are the header: HDR_ID (default C5H), line_num[7:0], and {std_code[3:0], 2'b00, line_num[9:8]}. The header is never recoded.
- R5: With recode_en high, a payload byte 00H is output as 03H and FFH is output as FCH. All other payload values are unchanged.
- R6: With recode_en low, payload bytes leave exactly as written, 00H and FFH included, in write order.
- R7: Two sections alternate. A second line can be captured while the first waits or is read out. Lines are output in capture order.
- R8: A line that starts while both sections are full is discarded entirely. drop_flag is set and stays set until reset. The buffered lines are unaffected.
- R9: A line holds at most MAX_BYTES (64) payload bytes. Bytes beyond that are ignored and the stored length is capped.
- R10: rd_grant has no effect while rd_req is low.
- R11: A byte written in the same cycle as line_end belongs to the line being closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Sliced byte present on wr_data |
| wr_data | input | 8 | Sliced payload byte |
| line_end | input | 1 | Closes the current line |
| line_num | input | 10 | Line number, sampled at line_end |
| std_code | input | 4 | Video standard code, sampled at line_end |
| recode_en | input | 1 | Substitute 00H/FFH in the payload |
| rd_grant | input | 1 | Bus grant for the pending line |
| rd_req | output | 1 | A complete line is waiting |
| rd_valid | output | 1 | Qualifier for rd_data |
| rd_data | output | 8 | Header and payload bytes |
| drop_flag | output | 1 | Sticky: a line was discarded |

## Verification
A wrong section pointer appears at the ports as a line that is repeated, skipped or swapped. This shows up in the header line number of the very next burst. A bad length or byte counter shows up within one burst: rd_valid falls early or late, or payload bytes appear shifted. A wrong full flag either raises rd_req in the middle of a line or leaves rd_req low after line_end. A section whose flag was never cleared raises rd_req with nothing new buffered, and that spurious request is seen in the cycle after the burst.

// File: rtl/vbi_line_pingpong.sv
module vbi_line_pingpong #(
  parameter int MAX_BYTES = 64,
  parameter int LN_W      = 10,
  parameter int STD_W     = 4,
  parameter logic [7:0] HDR_ID = 8'hC5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic [7:0]       wr_data,
  input  logic             line_end,
  input  logic [LN_W-1:0]  line_num,
  input  logic [STD_W-1:0] std_code,
  input  logic             recode_en,
  input  logic             rd_grant,
  output logic             rd_req,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  output logic             drop_flag
);
  localparam int CW   = $clog2(MAX_BYTES + 1);
  localparam int AW   = $clog2(MAX_BYTES);
  localparam int PW   = $clog2(MAX_BYTES + 3);
  localparam int PADW = 8 - STD_W - (LN_W - 8);

  logic [7:0]       mem  [2][MAX_BYTES];
  logic [CW-1:0]    len  [2];
  logic [LN_W-1:0]  lnq  [2];
  logic [STD_W-1:0] stdq [2];
  logic [1:0]       full;
  logic             wsel, rsel, in_line, discard, busy;
  logic [CW-1:0]    wcnt;
  logic [PW-1:0]    pos;

  logic starting, skip, take, commit, last;
  logic [AW-1:0] ridx;
  logic [7:0] raw, pay, hdr2;

  assign starting = !in_line && (wr_valid || line_end);
  assign skip     = discard || (starting && full[wsel]);
  assign take     = wr_valid && !skip && (wcnt < CW'(MAX_BYTES));
  assign commit   = line_end && !skip;
  assign last     = busy && (pos == PW'(len[rsel]) + PW'(2));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= '0; wsel <= 1'b0; rsel <= 1'b0; in_line <= 1'b0;
      discard <= 1'b0; busy <= 1'b0; wcnt <= '0; pos <= '0; drop_flag <= 1'b0;
    end else begin
      if (take) wcnt <= wcnt + CW'(1);
      if (wr_valid || line_end) in_line <= !line_end;
      if (starting && full[wsel]) begin
        discard   <= 1'b1;
        drop_flag <= 1'b1;
      end
      if (line_end) begin
        discard <= 1'b0;
        wcnt    <= '0;
      end
      if (commit) begin
        full[wsel] <= 1'b1;
        wsel       <= ~wsel;
      end
      if (rd_grant && rd_req) begin
        busy <= 1'b1;
        pos  <= '0;
      end else if (last) begin
        busy       <= 1'b0;
        full[rsel] <= 1'b0;
        rsel       <= ~rsel;
      end else if (busy) begin
        pos <= pos + PW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (take) mem[wsel][wcnt[AW-1:0]] <= wr_data;
    if (commit) begin
      len[wsel]  <= wcnt + CW'(take);
      lnq[wsel]  <= line_num;
      stdq[wsel] <= std_code;
    end
  end

  assign ridx = AW'(pos - PW'(3));
  assign raw  = mem[rsel][ridx];
  assign pay  = (recode_en && raw == 8'h00) ? 8'h03 :
                (recode_en && raw == 8'hFF) ? 8'hFC : raw;
  assign hdr2 = {stdq[rsel], {PADW{1'b0}}, lnq[rsel][LN_W-1:8]};

  assign rd_req   = full[rsel] && !busy;
  assign rd_valid = busy;
  assign rd_data  = !busy      ? 8'h00 :
                    pos == 0   ? HDR_ID :
                    pos == 1   ? lnq[rsel][7:0] :
                    pos == 2   ? hdr2 : pay;
endmodule

module vbi_line_pingpong_chk #(
  parameter logic [7:0] HDR_ID = 8'hC5,
  parameter int PW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_req,
  input logic          rd_grant,
  input logic          rd_valid,
  input logic [7:0]    rd_data,
  input logic          recode_en,
  input logic          drop_flag,
  input logic [PW-1:0] pos
);
  p_no_req_in_burst_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !rd_req);
  p_burst_needs_grant_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> $past(rd_grant && rd_req));
  p_drop_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    drop_flag |=> drop_flag);
  p_header_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> rd_data == HDR_ID);
  p_recoded_payload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && recode_en && pos >= PW'(3)) |-> (rd_data != 8'h00 && rd_data != 8'hFF));
endmodule

bind vbi_line_pingpong vbi_line_pingpong_chk #(.HDR_ID(HDR_ID), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_grant(rd_grant),
  .rd_valid(rd_valid), .rd_data(rd_data), .recode_en(recode_en),
  .drop_flag(drop_flag), .pos(pos)
);

// File: tb/sim_vbi_line_pingpong.sv
`timescale 1ns/1ps
module sim_vbi_line_pingpong;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 0, line_end = 0, recode_en = 0, rd_grant = 0;
  logic [7:0] wr_data = 0;
  logic [9:0] line_num = 0;
  logic [3:0] std_code = 0;
  logic rd_req, rd_valid, drop_flag;
  logic [7:0] rd_data;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  vbi_line_pingpong u0 (.clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .line_end(line_end), .line_num(line_num), .std_code(std_code), .recode_en(recode_en),
    .rd_grant(rd_grant), .rd_req(rd_req), .rd_valid(rd_valid), .rd_data(rd_data),
    .drop_flag(drop_flag));

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(int s, int k);
    if (k % 5 == 0) return 8'h00;
    if (k % 7 == 1) return 8'hFF;
    return 8'(s * 13 + k * 3 + 1);
  endfunction

  task automatic write_line(int n, int ln, int sd, int st, bit chk);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (chk) check(rd_req == 0, "R2 req low mid-line", rd_req, 0);
      wr_valid = 1; wr_data = pat(sd, k);
      line_end = (k == n - 1);
      line_num = 10'(ln); std_code = 4'(st);
    end
    @(negedge clk);
    wr_valid = 0; line_end = 0;
    if (chk) check(rd_req == 1, "R2 req after line_end", rd_req, 1);
  endtask

  task automatic read_line(int n, int ln, int sd, int st, bit rec, string tag);
    logic [7:0] e;
    @(negedge clk);
    check(rd_req == 1, {tag, " R7 line pending"}, rd_req, 1);
    recode_en = rec; rd_grant = 1;
    @(negedge clk);
    rd_grant = 0;
    for (int j = 0; j < n + 3; j++) begin
      if (j > 0) @(negedge clk);
      if (j == 0) e = 8'hC5;
      else if (j == 1) e = 8'(ln);
      else if (j == 2) e = {4'(st), 2'b00, 2'(ln >> 8)};
      else begin
        e = pat(sd, j - 3);
        if (rec && e == 8'h00) e = 8'h03;
        else if (rec && e == 8'hFF) e = 8'hFC;
      end
      check(rd_valid == 1, {tag, " R3 valid in burst"}, rd_valid, 1);
      check(rd_data == e, j < 3 ? {tag, " R4 header"} : rec ? {tag, " R5 recoded"} : {tag, " R6 raw"},
            rd_data, e);
    end
    @(negedge clk);
    check(rd_valid == 0, {tag, " R3 burst length"}, rd_valid, 0);
  endtask

  task automatic t_reset();
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(rd_req == 0 && rd_valid == 0, "R1 outputs idle", {rd_req, rd_valid}, 0);
    check(drop_flag == 0, "R1 drop clear", drop_flag, 0);
  endtask

  task automatic t_basic();
    write_line(10, 291, 1, 5, 1);
    read_line(10, 291, 1, 5, 0, "basic R11");
  endtask

  task automatic t_recode();
    write_line(20, 768, 2, 9, 1);
    read_line(20, 768, 2, 9, 1, "recode");
  endtask

  task automatic t_two();
    write_line(8, 100, 3, 1, 1);
    write_line(12, 513, 4, 2, 0);
    read_line(8, 100, 3, 1, 0, "order A");
    read_line(12, 513, 4, 2, 1, "order B");
  endtask

  task automatic t_overlap();
    write_line(30, 40, 5, 3, 1);
    fork
      read_line(30, 40, 5, 3, 0, "overlap C");
      write_line(15, 41, 6, 4, 0);
    join
    read_line(15, 41, 6, 4, 0, "overlap D");
  endtask

  task automatic t_drop();
    write_line(6, 200, 7, 6, 1);
    write_line(7, 201, 8, 7, 0);
    write_line(9, 202, 9, 8, 0);
    check(drop_flag == 1, "R8 drop set", drop_flag, 1);
    read_line(6, 200, 7, 6, 0, "drop E");
    read_line(7, 201, 8, 7, 0, "drop F");
    @(negedge clk);
    check(rd_req == 0, "R8 dropped line absent", rd_req, 0);
    check(drop_flag == 1, "R8 drop sticky", drop_flag, 1);
  endtask

  task automatic t_trunc();
    write_line(70, 999, 10, 15, 1);
    read_line(64, 999, 10, 15, 0, "R9 trunc");
  endtask

  task automatic t_grant();
    @(negedge clk);
    rd_grant = 1;
    @(negedge clk);
    rd_grant = 0;
    check(rd_valid == 0, "R10 grant ignored", rd_valid, 0);
    @(negedge clk);
    check(rd_valid == 0 && rd_req == 0, "R10 still idle", {rd_valid, rd_req}, 0);
    write_line(5, 7, 11, 0, 1);
    read_line(5, 7, 11, 0, 0, "R10 after");
  endtask

  initial begin
    t_reset();
    t_basic();
    t_recode();
    t_two();
    t_overlap();
    t_drop();
    t_trunc();
    t_grant();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule